// File: doc/BRIEF.md
# Binary Row Correlation Engine

This block answers one kind of query on a binary matrix stored in a word-addressed memory: which rows share at least one set column with a chosen row. A query gives the row index, the matrix dimensions and the base address. The engine copies the chosen row into a private row buffer. It then streams every row of the matrix through a single synchronous read port, one 64-bit word per cycle. Each memory word is ANDed with the matching buffered word, and the OR of these products is collected per row. The answer is a vector with one bit per row, together with a one-cycle completion pulse.

Finished answers are saved in a small cache that is tagged by the chosen row. Asking for the same row again returns the saved vector at once and reads no memory. Whoever rewrites the matrix pulses the clear input, which drops every saved answer.

Top module: `rowcorr_engine`

## Requirements
- R1: After reset, `done`, `cached` and `mem_rd_en` are low and `result` is all zeros.
- R2: For a query on row s, bit j of `result` is 1 exactly when row j and row s both hold a 1 in some column below `num_cols`. Bits at positions `num_rows` and above are 0.
- R3: Column c of a row lives in word c/64 at bit c%64. Bits of the last word at or beyond `num_cols` never affect the result, whatever their value.
- R4: With W = ceil(`num_cols`/64), row j word k is at `base_addr` + j*W + k. A missing query reads the W words of the selected row in ascending order. It then reads all `num_rows`*W matrix words in ascending address order. There is one read per cycle with no gaps, and `mem_rdata` is used in the cycle after its read.
- R5: On a miss, `done` is high in the cycle that follows the (3 + W + `num_rows`*W)-th rising edge after the edge that samples `start`. It stays high for exactly one cycle.
- R6: A query whose row is held in the cache raises `done` one edge after `start` is sampled. It returns the saved vector with `cached` high and issues no memory read. A computed answer has `cached` low.
- R7: The cache holds CACHE_N answers, each under a distinct row tag. A miss replaces entries in round-robin order, so after CACHE_N further distinct misses the oldest entry is gone.
- R8: A `cache_clr` pulse invalidates every entry, so the next query for any row is a miss.
- R9: `start` is ignored while a query is in progress. Timing, addresses and the result of that query are unchanged.
- Valid commands use 1 <= `num_rows` <= MAX_ROWS and 1 <= `num_cols` <= MAX_WORDS*64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Query request, sampled while idle |
| sel_row | input | ROW_W | Row to correlate against |
| num_rows | input | NROW_W | Number of matrix rows |
| num_cols | input | COL_W | Number of matrix columns |
| base_addr | input | ADDR_W | Address of row 0 word 0 |
| cache_clr | input | 1 | Invalidate all cached answers |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_addr | output | ADDR_W | Memory word address |
| mem_rdata | input | DATA_W | Read data, one cycle after the strobe |
| result | output | MAX_ROWS | Correlation vector |
| done | output | 1 | One-cycle pulse: result valid |
| cached | output | 1 | Result came from the cache |

## Verification
On every cycle, the assertions check the following:
- `done` is a single-cycle pulse.
- Scan reads advance the address by exactly one.
- Copy writes stay inside the active word count.
- A cache hit issues no read.
- Unused result bits are zero, and the per-row OR never drops back to zero within a row.
- Cache tags are unique, and a clear empties the cache.

Some behaviours need the bench's scenarios:
- the correct correlation bits over varied matrices;
- masking of padding columns;
- round-robin eviction order;
- the hit/miss decision after a clear;
- the indifference to a `start` that arrives while busy.

The bench shows these by comparing the read strobe, the address and `done` against a behavioural model in every cycle of a query.

// File: rtl/rowcorr_pkg.sv
package rowcorr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_LOAD,
    ST_SCAN,
    ST_FLUSH,
    ST_DONE
  } ctrl_state_e;

  function automatic int unsigned clog2_min1(input int unsigned v);
    return (v <= 2) ? 1 : $clog2(v);
  endfunction

endpackage

// File: rtl/rowcorr_rowbuf.sv
module rowcorr_rowbuf #(
  parameter int DATA_W = 64,
  parameter int DEPTH  = 4,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] word_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) word_q[wr_idx] <= wr_data;
  end

  assign rd_data = word_q[rd_idx];

endmodule

// File: rtl/rowcorr_accum.sv
module rowcorr_accum #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              first,
  input  logic [DATA_W-1:0] mem_word,
  input  logic [DATA_W-1:0] buf_word,
  input  logic [DATA_W-1:0] mask,
  output logic              row_hit
);

  logic acc_q;
  logic word_hit;

  assign word_hit = |(mem_word & buf_word & mask);
  assign row_hit  = (first ? 1'b0 : acc_q) | word_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  acc_q <= 1'b0;
    else if (en) acc_q <= row_hit;
  end

  // R2: inside one row, once a shared bit is found the row stays marked
  p_sticky_or_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !first && $past(en) && $past(row_hit)) |-> row_hit);

endmodule

// File: rtl/rowcorr_cache.sv
module rowcorr_cache #(
  parameter int TAG_W  = 4,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [TAG_W-1:0]  lk_tag,
  output logic              lk_hit,
  output logic [DATA_W-1:0] lk_data,
  input  logic              wr_en,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data
);

  localparam int PTR_W = rowcorr_pkg::clog2_min1(DEPTH);

  logic [DEPTH-1:0]  vld_q;
  logic [DEPTH-1:0]  match;
  logic [TAG_W-1:0]  tag_q [DEPTH];
  logic [DATA_W-1:0] dat_q [DEPTH];
  logic [PTR_W-1:0]  rr_q, rr_d;

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    assign match[i] = vld_q[i] && (tag_q[i] == lk_tag);

    always_ff @(posedge clk) begin
      if (wr_en && !clr && (rr_q == PTR_W'(i))) begin
        tag_q[i] <= wr_tag;
        dat_q[i] <= wr_data;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 vld_q[i] <= 1'b0;
      else if (clr)                               vld_q[i] <= 1'b0;
      else if (wr_en && (rr_q == PTR_W'(i)))      vld_q[i] <= 1'b1;
    end
  end

  always_comb begin
    lk_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (match[i]) lk_data = lk_data | dat_q[i];
    end
  end

  assign lk_hit = |match;

  always_comb begin
    rr_d = rr_q;
    if (wr_en && !clr) rr_d = (rr_q == PTR_W'(DEPTH - 1)) ? '0 : rr_q + PTR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rr_q <= '0;
    else        rr_q <= rr_d;
  end

  // R7: no row is ever held twice
  p_tag_unique_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));

  // R8: a clear leaves no valid entry behind
  p_clear_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (vld_q == '0));

endmodule

// File: rtl/rowcorr_engine.sv
module rowcorr_engine
  import rowcorr_pkg::*;
#(
  parameter int DATA_W    = 64,
  parameter int ADDR_W    = 12,
  parameter int MAX_ROWS  = 16,
  parameter int MAX_WORDS = 4,
  parameter int CACHE_N   = 4,
  localparam int ROW_W    = clog2_min1(MAX_ROWS),
  localparam int NROW_W   = $clog2(MAX_ROWS + 1),
  localparam int COL_W    = $clog2(MAX_WORDS * DATA_W + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [ROW_W-1:0]    sel_row,
  input  logic [NROW_W-1:0]   num_rows,
  input  logic [COL_W-1:0]    num_cols,
  input  logic [ADDR_W-1:0]   base_addr,
  input  logic                cache_clr,
  output logic                mem_rd_en,
  output logic [ADDR_W-1:0]   mem_addr,
  input  logic [DATA_W-1:0]   mem_rdata,
  output logic [MAX_ROWS-1:0] result,
  output logic                done,
  output logic                cached
);

  localparam int WIDX_W = clog2_min1(MAX_WORDS);
  localparam int WCNT_W = $clog2(MAX_WORDS + 1);
  localparam int BIT_W  = $clog2(DATA_W);

  ctrl_state_e         state_q, state_d;
  logic [ROW_W-1:0]    sel_q, sel_d;
  logic [NROW_W-1:0]   rows_q, rows_d;
  logic [WCNT_W-1:0]   words_q, words_d;
  logic [DATA_W-1:0]   mask_q, mask_d;
  logic [ADDR_W-1:0]   base_q, base_d;
  logic [ADDR_W-1:0]   ptr_q, ptr_d;
  logic [WIDX_W-1:0]   wcnt_q, wcnt_d;
  logic [ROW_W-1:0]    rcnt_q, rcnt_d;
  logic [MAX_ROWS-1:0] result_q, result_d;
  logic                cached_q, cached_d;

  logic                ret_vld_q, ret_scan_q, ret_last_q;
  logic [WIDX_W-1:0]   ret_widx_q;
  logic [ROW_W-1:0]    ret_row_q;

  logic [COL_W:0]      cols_round;
  logic [BIT_W-1:0]    tail_bits;
  logic                last_word, last_row;
  logic                issue;
  logic                buf_wr;
  logic [DATA_W-1:0]   buf_word;
  logic                acc_en, acc_first, row_hit;
  logic [DATA_W-1:0]   acc_mask;
  logic                lk_hit;
  logic [MAX_ROWS-1:0] lk_data;
  logic                cache_wr;

  // command decode
  assign cols_round = {1'b0, num_cols} + (COL_W + 1)'(DATA_W - 1);
  assign tail_bits  = num_cols[BIT_W-1:0];

  assign last_word = (WCNT_W'(wcnt_q) == words_q - WCNT_W'(1));
  assign last_row  = (NROW_W'(rcnt_q) == rows_q - NROW_W'(1));
  assign issue     = (state_q == ST_LOAD) || (state_q == ST_SCAN);

  // next-state process
  always_comb begin
    state_d  = state_q;
    sel_d    = sel_q;
    rows_d   = rows_q;
    words_d  = words_q;
    mask_d   = mask_q;
    base_d   = base_q;
    ptr_d    = ptr_q;
    wcnt_d   = wcnt_q;
    rcnt_d   = rcnt_q;
    result_d = result_q;
    cached_d = cached_q;
    cache_wr = 1'b0;

    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          sel_d   = sel_row;
          rows_d  = num_rows;
          words_d = WCNT_W'(cols_round >> BIT_W);
          mask_d  = (tail_bits == '0) ? '1
                  : ((DATA_W'(1) << tail_bits) - DATA_W'(1));
          base_d  = base_addr;
          state_d = ST_LOOKUP;
        end
      end
      ST_LOOKUP: begin
        if (lk_hit) begin
          result_d = lk_data;
          cached_d = 1'b1;
          state_d  = ST_DONE;
        end else begin
          result_d = '0;
          cached_d = 1'b0;
          ptr_d    = base_q + ADDR_W'(sel_q) * ADDR_W'(words_q);
          wcnt_d   = '0;
          state_d  = ST_LOAD;
        end
      end
      ST_LOAD: begin
        ptr_d = ptr_q + ADDR_W'(1);
        if (last_word) begin
          wcnt_d  = '0;
          rcnt_d  = '0;
          ptr_d   = base_q;
          state_d = ST_SCAN;
        end else begin
          wcnt_d = wcnt_q + WIDX_W'(1);
        end
      end
      ST_SCAN: begin
        ptr_d = ptr_q + ADDR_W'(1);
        if (last_word) begin
          wcnt_d = '0;
          if (last_row) state_d = ST_FLUSH;
          else          rcnt_d  = rcnt_q + ROW_W'(1);
        end else begin
          wcnt_d = wcnt_q + WIDX_W'(1);
        end
      end
      ST_FLUSH: begin
        if (!ret_vld_q) begin
          cache_wr = 1'b1;
          state_d  = ST_DONE;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase

    // returning scan word closes a row
    if (acc_en && ret_last_q) result_d[ret_row_q] = row_hit;
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      sel_q      <= '0;
      rows_q     <= '0;
      words_q    <= '0;
      mask_q     <= '0;
      base_q     <= '0;
      ptr_q      <= '0;
      wcnt_q     <= '0;
      rcnt_q     <= '0;
      result_q   <= '0;
      cached_q   <= 1'b0;
      ret_vld_q  <= 1'b0;
      ret_scan_q <= 1'b0;
      ret_last_q <= 1'b0;
      ret_widx_q <= '0;
      ret_row_q  <= '0;
    end else begin
      state_q    <= state_d;
      sel_q      <= sel_d;
      rows_q     <= rows_d;
      words_q    <= words_d;
      mask_q     <= mask_d;
      base_q     <= base_d;
      ptr_q      <= ptr_d;
      wcnt_q     <= wcnt_d;
      rcnt_q     <= rcnt_d;
      result_q   <= result_d;
      cached_q   <= cached_d;
      ret_vld_q  <= issue;
      ret_scan_q <= (state_q == ST_SCAN);
      ret_last_q <= last_word;
      ret_widx_q <= wcnt_q;
      ret_row_q  <= rcnt_q;
    end
  end

  // returning-data path
  assign buf_wr    = ret_vld_q && !ret_scan_q;
  assign acc_en    = ret_vld_q && ret_scan_q;
  assign acc_first = (ret_widx_q == '0);
  assign acc_mask  = ret_last_q ? mask_q : '1;

  rowcorr_rowbuf #(
    .DATA_W (DATA_W),
    .DEPTH  (MAX_WORDS),
    .IDX_W  (WIDX_W)
  ) u_rowbuf (
    .clk     (clk),
    .wr_en   (buf_wr),
    .wr_idx  (ret_widx_q),
    .wr_data (mem_rdata),
    .rd_idx  (ret_widx_q),
    .rd_data (buf_word)
  );

  rowcorr_accum #(
    .DATA_W (DATA_W)
  ) u_accum (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (acc_en),
    .first    (acc_first),
    .mem_word (mem_rdata),
    .buf_word (buf_word),
    .mask     (acc_mask),
    .row_hit  (row_hit)
  );

  rowcorr_cache #(
    .TAG_W  (ROW_W),
    .DATA_W (MAX_ROWS),
    .DEPTH  (CACHE_N)
  ) u_cache (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (cache_clr),
    .lk_tag  (sel_q),
    .lk_hit  (lk_hit),
    .lk_data (lk_data),
    .wr_en   (cache_wr),
    .wr_tag  (sel_q),
    .wr_data (result_q)
  );

  assign mem_rd_en = issue;
  assign mem_addr  = ptr_q;
  assign result    = result_q;
  assign done      = (state_q == ST_DONE);
  assign cached    = cached_q;

  // R5: completion is a single-cycle pulse
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R4: matrix scan reads consecutive words with no gap
  p_scan_contiguous_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_SCAN) && $past(state_q == ST_SCAN))
      |-> (mem_addr == $past(mem_addr) + ADDR_W'(1)));

  // R4: row-buffer fills stay inside the active word count
  p_copy_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    buf_wr |-> (WCNT_W'(ret_widx_q) < words_q));

  // R6: a cache hit never touches memory
  p_no_read_on_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_LOOKUP) && lk_hit) |=> !mem_rd_en);

  // R2: rows past the matrix height report zero
  p_unused_rows_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !cached) |-> ((result >> rows_q) == '0));

endmodule

// File: tb/rowcorr_engine_tb.sv
`timescale 1ns/1ps
module rowcorr_engine_tb;

  localparam int NR = 16;
  localparam int NC = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [3:0]  sel_row;
  logic [4:0]  num_rows;
  logic [8:0]  num_cols;
  logic [11:0] base_addr;
  logic        cache_clr;
  logic        mem_rd_en;
  logic [11:0] mem_addr;
  logic [63:0] mem_rdata;
  logic [15:0] result;
  logic        done;
  logic        cached;

  always #2 clk = ~clk;

  rowcorr_engine u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .sel_row(sel_row),
    .num_rows(num_rows), .num_cols(num_cols), .base_addr(base_addr),
    .cache_clr(cache_clr), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .result(result), .done(done), .cached(cached)
  );

  logic [63:0] mem [4096];
  always @(posedge clk) if (mem_rd_en) mem_rdata <= mem[mem_addr];

  int checks = 0;
  int fails  = 0;
  int g_rows, g_cols, g_base;

  // behavioural cache model
  int          m_tag [NC];
  bit          m_vld [NC];
  logic [15:0] m_dat [NC];
  int          m_rr = 0;

  logic [63:0] rng = 64'h9E3779B97F4A7C15;

  function automatic logic [63:0] rnd();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 7);
    rng = rng ^ (rng << 17);
    return rng;
  endfunction

  function automatic logic [63:0] sparse();
    return rnd() & rnd() & rnd() & rnd() & rnd();
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] ref_vec(input int sel);
    logic [15:0] v = '0;
    int w = (g_cols + 63) / 64;
    for (int j = 0; j < g_rows; j++)
      for (int c = 0; c < g_cols; c++)
        if (mem[g_base + j*w + c/64][c%64] && mem[g_base + sel*w + c/64][c%64])
          v[j] = 1'b1;
    return v;
  endfunction

  task automatic do_clear();
    @(negedge clk) cache_clr = 1'b1;
    @(posedge clk) #1 cache_clr = 1'b0;
    for (int i = 0; i < NC; i++) m_vld[i] = 1'b0;
  endtask

  // one query, compared with the model in every cycle
  task automatic query(input int sel, input int poke);
    int          w = (g_cols + 63) / 64;
    int          nrd;
    int          lat;
    int          hit_i = -1;
    logic [15:0] expv;
    int          addrs [$];
    for (int i = 0; i < NC; i++) if (m_vld[i] && m_tag[i] == sel) hit_i = i;
    expv = ref_vec(sel);
    if (hit_i >= 0) begin
      expv = m_dat[hit_i];
      nrd  = 0;
      lat  = 1;
    end else begin
      for (int k = 0; k < w; k++) addrs.push_back(g_base + sel*w + k);
      for (int i = 0; i < g_rows*w; i++) addrs.push_back(g_base + i);
      nrd = w + g_rows*w;
      lat = 3 + w + g_rows*w;
      m_tag[m_rr] = sel; m_vld[m_rr] = 1'b1; m_dat[m_rr] = expv;
      m_rr = (m_rr + 1) % NC;
    end
    @(negedge clk);
    start = 1'b1; sel_row = 4'(sel); num_rows = 5'(g_rows);
    num_cols = 9'(g_cols); base_addr = 12'(g_base);
    @(posedge clk) #1 start = 1'b0;
    for (int c = 1; c <= lat; c++) begin
      @(posedge clk) #1 start = 1'b0;
      @(negedge clk);
      if (c <= nrd) begin
        chk(mem_rd_en === 1'b1, "R4 read strobe", 64'(mem_rd_en), 1);
        chk(mem_addr === 12'(addrs[c-1]), "R4 read address", 64'(mem_addr), 64'(addrs[c-1]));
      end else begin
        chk(mem_rd_en === 1'b0, (hit_i >= 0) ? "R6 no read on hit" : "R4 read idle",
            64'(mem_rd_en), 0);
      end
      chk(done === (c == lat), (hit_i >= 0) ? "R6 hit latency" : "R5 miss latency",
          64'(done), 64'(c == lat));
      if (c == poke) begin
        start = 1'b1;  // R9: request while busy must be ignored
        sel_row = 4'(sel ^ 1);
      end
    end
    chk(result === expv, (hit_i >= 0) ? "R6 cached vector" : "R2 R3 correlation vector",
        64'(result), 64'(expv));
    chk(cached === (hit_i >= 0), "R6 cached flag", 64'(cached), 64'(hit_i >= 0));
    @(negedge clk);
    chk(done === 1'b0, "R5 single-cycle done", 64'(done), 0);
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; cache_clr = 1'b0;
    sel_row = '0; num_rows = '0; num_cols = '0; base_addr = '0;
    for (int i = 0; i < NC; i++) m_vld[i] = 1'b0;
    for (int i = 0; i < 4096; i++) mem[i] = 64'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(done === 1'b0, "R1 done", 64'(done), 0);
    chk(mem_rd_en === 1'b0, "R1 read strobe", 64'(mem_rd_en), 0);
    chk(result === 16'h0, "R1 result", 64'(result), 0);
    chk(cached === 1'b0, "R1 cached", 64'(cached), 0);

    // set A: 12 rows x 150 cols, random padding bits
    g_rows = 12; g_cols = 150; g_base = 'h20;
    for (int j = 0; j < 12; j++)
      for (int k = 0; k < 3; k++) mem[g_base + j*3 + k] = sparse();
    for (int k = 0; k < 3; k++) mem[g_base + 6*3 + k] = 64'h0;
    query(3, 0);   // R2 miss
    query(3, 0);   // R6 hit
    query(0, 0);
    query(11, 0);
    query(5, 4);   // R9 start while busy
    query(7, 0);   // R7 evicts row 3
    query(3, 0);   // R7 miss again, evicts row 0
    query(11, 0);  // R7 still held
    query(0, 0);   // R7 evicted earlier
    do_clear();
    query(11, 0);  // R8 miss after clear

    // set B: 10 rows x 70 cols, every padding bit set
    do_clear();
    g_rows = 10; g_cols = 70; g_base = 'h100;
    for (int j = 0; j < 10; j++) begin
      mem[g_base + j*2]     = sparse();
      mem[g_base + j*2 + 1] = (sparse() & 64'h3F) | ~64'h3F;
    end
    mem[g_base + 8]     = 64'h0;
    mem[g_base + 8 + 1] = ~64'h3F;
    query(4, 0);   // R3 padding only: all zero
    query(2, 0);

    // set C: 16 rows x 64 cols, single word per row
    do_clear();
    g_rows = 16; g_cols = 64; g_base = 'h200;
    for (int j = 0; j < 16; j++) mem[g_base + j] = sparse();
    query(15, 0);
    query(15, 0);

    // set D: one row of 256 cols
    do_clear();
    g_rows = 1; g_cols = 256; g_base = 'h300;
    for (int k = 0; k < 4; k++) mem[g_base + k] = (k == 3) ? 64'h8000_0000_0000_0000 : 64'h0;
    query(0, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule